// File: doc/BRIEF.md
# Switch-Addressed Four-Byte I/O Output Port

This block sits on the peripheral side of an 8-bit, ISA-style I/O bus. It watches the bus for I/O write cycles. When a cycle's address falls in a four-byte window, the block stores the data byte in one of four byte latches. Together the four latches drive a 32-bit parallel output word. The window's base comes from a set of switch inputs. The card can therefore be moved in the I/O map so that it does not clash with other cards.

The active-low write strobe is sampled by the system clock. While the strobe is low, the block records the address decode, the lane select and the data byte on every clock. The byte is written into the chosen latch in the clock edge that first sees the strobe high again, which is the trailing edge. When AEN is high, the decode is suppressed, so DMA cycles cannot write a latch. Each output byte has its own enable. When a lane is disabled, its output byte reads zero and its valid flag is low, which stands in for a high-impedance driver. The stored value is kept.

Top module: `io_port_latch_bank`

## Requirements
- R1: While reset is active, and after it is released, all four latches hold 0x00. A reset asserted later clears them again.
- R2: A matching write stores its data byte. The byte is visible on the output after the clock edge that first samples the strobe high, and not before.
- R3: A write is accepted only if address bits 15:2 equal the switch base value. Any other address leaves all latches unchanged.
- R4: If AEN is high while the strobe is low, the cycle writes nothing.
- R5: A write changes only the addressed byte. The other three bytes keep their values.
- R6: While the strobe stays low, no latch changes. If the data changes during the strobe, the value sampled on the last clock before the strobe rises is the one stored.
- R7: When a lane's enable is low, that output byte reads 0x00 and its valid bit is 0. When the enable returns high, the stored value reappears.
- R8: Changing the switch base moves the window. The old addresses stop writing and the new ones work.
- R9: Address bits 1:0 select the lane. Value 0 drives word bits 7:0, value 1 drives bits 15:8, value 2 drives bits 23:16 and value 3 drives bits 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 16 | I/O address lines 15:0 |
| data_i | input | 8 | Bus data byte |
| iow_n_i | input | 1 | Active-low I/O write strobe |
| aen_i | input | 1 | Address enable; high during DMA, which suppresses decode |
| base_sw_i | input | 14 | Switch-set base, compared with address bits 15:2 |
| out_en_i | input | 4 | Per-lane output enable, active high |
| word_o | output | 32 | Latched 32-bit output word; disabled lanes read zero |
| lane_vld_o | output | 4 | Per-lane valid flag (low means the lane is off the bus) |

## Verification
The assertions check four behaviours on every cycle:
- No latch moves unless the strobe is released.
- A cycle with AEN high never commits.
- A committed byte lands in the selected lane.
- A disabled lane reads zero with its valid flag low.

Only the bench's scenarios can show four others. These are that the base compare rejects neighbouring addresses, that moving the switches relocates the window, that the lane-to-bit-position order holds, and that the last byte sampled during a long strobe is the one stored.

// File: rtl/io_port_pkg.sv
// Package: shared defaults and types for the switch-addressed output port.
// Assumes lane count is a power of two so address low bits select a lane.
package io_port_pkg;
    localparam int DEF_ADDR_W = 16;
    localparam int DEF_BYTE_W = 8;
    localparam int DEF_LANES  = 4;

    // Strobe tracker state: records whether the last sample saw the strobe low.
    typedef enum logic {
        STB_HIGH = 1'b0,
        STB_LOW  = 1'b1
    } strobe_st_e;
endpackage

// File: rtl/io_addr_decode.sv
// Module: combinational I/O address decoder.
// Compares the upper address bits with the switch base. It also splits off the
// lane select and suppresses the match while AEN is high. No state.
module io_addr_decode #(
    parameter int ADDR_W = 16,
    parameter int SEL_W  = 2,
    localparam int BASE_W = ADDR_W - SEL_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic              aen_i,
    output logic              hit_o,
    output logic [SEL_W-1:0]  sel_o
);
    // Decode: base compare gated by AEN, lane from the low bits.
    always_comb begin
        hit_o = (addr_i[ADDR_W-1:SEL_W] == base_i) && !aen_i;
        sel_o = addr_i[SEL_W-1:0];
    end
endmodule

// File: rtl/io_strobe_capture.sv
// Module: samples the active-low write strobe with the system clock.
// While the strobe is low it records the decode result, lane and data every
// clock. It raises a commit in the cycle where the strobe is first seen high.
// Assumes the strobe is already synchronous to clk.
module io_strobe_capture
    import io_port_pkg::*;
#(
    parameter int SEL_W  = 2,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iow_n_i,
    input  logic              hit_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic              strobe_low_o,
    output logic              commit_o,
    output logic [SEL_W-1:0]  commit_sel_o,
    output logic [BYTE_W-1:0] commit_data_o
);
    strobe_st_e        st_q;
    logic              snap_hit_q;
    logic [SEL_W-1:0]  snap_sel_q;
    logic [BYTE_W-1:0] snap_data_q;

    // Track the strobe level seen on the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= STB_HIGH;
        else        st_q <= iow_n_i ? STB_HIGH : STB_LOW;
    end

    // Record decode, lane and data on every clock while the strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_hit_q  <= 1'b0;
            snap_sel_q  <= '0;
            snap_data_q <= '0;
        end else if (!iow_n_i) begin
            snap_hit_q  <= hit_i;
            snap_sel_q  <= sel_i;
            snap_data_q <= data_i;
        end
    end

    // Commit on the trailing edge if the last low sample matched.
    always_comb begin
        strobe_low_o  = (st_q == STB_LOW);
        commit_o      = iow_n_i && strobe_low_o && snap_hit_q;
        commit_sel_o  = snap_sel_q;
        commit_data_o = snap_data_q;
    end
endmodule

// File: rtl/io_lane_latch.sv
// Module: one byte latch with an output enable.
// Loads on wr_i and clears on reset. When disabled, the output reads zero and
// valid is low, which models a released driver. Stored data is kept.
module io_lane_latch #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [BYTE_W-1:0] din_i,
    input  logic              oe_i,
    output logic [BYTE_W-1:0] raw_o,
    output logic [BYTE_W-1:0] q_o,
    output logic              vld_o
);
    logic [BYTE_W-1:0] store_q;

    // Storage: cleared by reset, loaded on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)    store_q <= '0;
        else if (wr_i) store_q <= din_i;
    end

    // Output gate by the lane enable.
    always_comb begin
        raw_o = store_q;
        q_o   = oe_i ? store_q : '0;
        vld_o = oe_i;
    end
endmodule

// File: rtl/io_port_latch_bank.sv
// Module: top of the switch-addressed output port.
// Decodes I/O writes against a switch base and commits a byte on the strobe's
// trailing edge. Each lane latch drives its own slice of the output word.
// Assumes LANES is a power of two and all bus inputs are synchronous to clk.
module io_port_latch_bank
    import io_port_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int BYTE_W = DEF_BYTE_W,
    parameter int LANES  = DEF_LANES,
    localparam int SEL_W  = $clog2(LANES),
    localparam int BASE_W = ADDR_W - SEL_W,
    localparam int WORD_W = BYTE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] data_i,
    input  logic              iow_n_i,
    input  logic              aen_i,
    input  logic [BASE_W-1:0] base_sw_i,
    input  logic [LANES-1:0]  out_en_i,
    output logic [WORD_W-1:0] word_o,
    output logic [LANES-1:0]  lane_vld_o
);
    logic              hit;
    logic [SEL_W-1:0]  sel;
    logic              strobe_low;
    logic              commit;
    logic [SEL_W-1:0]  commit_sel;
    logic [BYTE_W-1:0] commit_data;
    logic [LANES-1:0]  wr_vec;
    logic [WORD_W-1:0] raw_word;

    io_addr_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_dec (
        .addr_i (addr_i),
        .base_i (base_sw_i),
        .aen_i  (aen_i),
        .hit_o  (hit),
        .sel_o  (sel)
    );

    io_strobe_capture #(.SEL_W(SEL_W), .BYTE_W(BYTE_W)) u_stb (
        .clk           (clk),
        .rst_n         (rst_n),
        .iow_n_i       (iow_n_i),
        .hit_i         (hit),
        .sel_i         (sel),
        .data_i        (data_i),
        .strobe_low_o  (strobe_low),
        .commit_o      (commit),
        .commit_sel_o  (commit_sel),
        .commit_data_o (commit_data)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Lane write enable: a commit aimed at this lane.
        always_comb wr_vec[g] = commit && (commit_sel == SEL_W'(g));

        io_lane_latch #(.BYTE_W(BYTE_W)) u_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_i  (wr_vec[g]),
            .din_i (commit_data),
            .oe_i  (out_en_i[g]),
            .raw_o (raw_word[g*BYTE_W +: BYTE_W]),
            .q_o   (word_o[g*BYTE_W +: BYTE_W]),
            .vld_o (lane_vld_o[g])
        );
    end
endmodule

// File: rtl/io_port_latch_bank_chk.sv
// Module: assertion checker bound to io_port_latch_bank.
// It observes ports and internal commit signals and drives nothing.
module io_port_latch_bank_chk #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    parameter int SEL_W  = 2,
    localparam int WORD_W = BYTE_W * LANES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              iow_n_i,
    input logic              aen_i,
    input logic [LANES-1:0]  out_en_i,
    input logic [WORD_W-1:0] word_o,
    input logic [LANES-1:0]  lane_vld_o,
    input logic              strobe_low,
    input logic              commit,
    input logic [SEL_W-1:0]  commit_sel,
    input logic [BYTE_W-1:0] commit_data,
    input logic [WORD_W-1:0] raw_word
);
    // R6: storage holds unless the strobe is released after a low sample.
    a_r6_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!iow_n_i || !strobe_low) |=> $stable(raw_word));

    // R4: a low-strobe sample taken with AEN high can never commit next cycle.
    a_r4_aen_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!iow_n_i && aen_i) |=> !commit);

    // R2: a committed byte appears in the selected lane.
    a_r2_byte_lands: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (raw_word[$past(commit_sel)*BYTE_W +: BYTE_W] == $past(commit_data)));

    for (genvar g = 0; g < LANES; g++) begin : g_oe
        // R7: a disabled lane reads zero and is flagged invalid.
        a_r7_lane_hidden: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en_i[g] |-> (word_o[g*BYTE_W +: BYTE_W] == '0) && !lane_vld_o[g]);
        // R7: an enabled lane shows its stored byte.
        a_r7_lane_shown: assert property (@(posedge clk) disable iff (!rst_n)
            out_en_i[g] |-> (word_o[g*BYTE_W +: BYTE_W] == raw_word[g*BYTE_W +: BYTE_W])
                            && lane_vld_o[g]);
    end
endmodule

bind io_port_latch_bank io_port_latch_bank_chk #(
    .BYTE_W(BYTE_W), .LANES(LANES), .SEL_W(SEL_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .iow_n_i     (iow_n_i),
    .aen_i       (aen_i),
    .out_en_i    (out_en_i),
    .word_o      (word_o),
    .lane_vld_o  (lane_vld_o),
    .strobe_low  (strobe_low),
    .commit      (commit),
    .commit_sel  (commit_sel),
    .commit_data (commit_data),
    .raw_word    (raw_word)
);

// File: tb/tb_io_port_latch_bank.sv
// Scoreboard bench: driver tasks push expected words, a monitor pops and compares.
module tb_io_port_latch_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr_i = '0;
    logic [7:0]  data_i = '0;
    logic        iow_n_i = 1'b1;
    logic        aen_i = 1'b0;
    logic [13:0] base_sw_i = 14'h00C0;
    logic [3:0]  out_en_i = 4'hF;
    logic [31:0] word_o;
    logic [3:0]  lane_vld_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] word;
        logic [3:0]  vld;
        string       tag;
    } exp_t;
    exp_t sb_q[$];
    event mon_ev;

    logic [7:0] mdl [4];

    always #4 clk = ~clk;

    io_port_latch_bank dut (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .data_i(data_i),
        .iow_n_i(iow_n_i), .aen_i(aen_i), .base_sw_i(base_sw_i),
        .out_en_i(out_en_i), .word_o(word_o), .lane_vld_o(lane_vld_o)
    );

    // Monitor: pop one expected item per request and compare it with the ports.
    always begin
        @(mon_ev);
        #1;
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (word_o !== e.word || lane_vld_o !== e.vld) begin
                errors++;
                $display("FAIL %s: word=%h vld=%b expected word=%h vld=%b",
                         e.tag, word_o, lane_vld_o, e.word, e.vld);
            end
        end
    end

    // Push the model's view of the output and ask the monitor to check it.
    task automatic expect_now(input string tag);
        exp_t e;
        e.tag = tag;
        for (int i = 0; i < 4; i++) begin
            e.word[i*8 +: 8] = out_en_i[i] ? mdl[i] : 8'h00;
            e.vld[i] = out_en_i[i];
        end
        sb_q.push_back(e);
        -> mon_ev;
        #2;
    endtask

    // One bus write: strobe low for three clocks, then released.
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d,
                             input logic aen, input bit accept, input string tag);
        @(negedge clk);
        addr_i = a; data_i = d; aen_i = aen; iow_n_i = 1'b0;
        repeat (3) @(negedge clk);
        iow_n_i = 1'b1;
        @(negedge clk);
        if (accept) mdl[a[1:0]] = d;
        expect_now(tag);
        aen_i = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
        repeat (3) @(negedge clk);
        expect_now("R1 state during reset");
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R1 state after reset");

        // R2 and R9: one byte per lane, with the lane given by address bits 1:0.
        bus_write(16'h0300, 8'hA5, 1'b0, 1'b1, "R2 lane0 write");
        bus_write(16'h0303, 8'h3C, 1'b0, 1'b1, "R9 lane3 at bits 31:24");
        bus_write(16'h0301, 8'h11, 1'b0, 1'b1, "R9 lane1 at bits 15:8");
        bus_write(16'h0302, 8'hE7, 1'b0, 1'b1, "R5 lane2 only, others held");
        bus_write(16'h0300, 8'h5A, 1'b0, 1'b1, "R5 lane0 overwrite");

        // R3: addresses next to the window.
        bus_write(16'h0304, 8'hFF, 1'b0, 1'b0, "R3 address above window");
        bus_write(16'h02FF, 8'hFF, 1'b0, 1'b0, "R3 address below window");
        bus_write(16'h8300, 8'hFF, 1'b0, 1'b0, "R3 high bit differs");

        // R4: the address matches, but AEN is high.
        bus_write(16'h0301, 8'h99, 1'b1, 1'b0, "R4 AEN suppresses write");

        // R6: the data changes during a long strobe, and nothing moves before release.
        @(negedge clk);
        addr_i = 16'h0302; data_i = 8'h01; iow_n_i = 1'b0;
        repeat (2) @(negedge clk);
        expect_now("R6 no change while strobe low");
        data_i = 8'h77;
        repeat (2) @(negedge clk);
        expect_now("R6 still held before release");
        iow_n_i = 1'b1;
        @(negedge clk);
        mdl[2] = 8'h77;
        expect_now("R6 last sampled byte stored");

        // R2: the timing of a write.
        @(negedge clk);
        addr_i = 16'h0303; data_i = 8'hC4; iow_n_i = 1'b0;
        repeat (2) @(negedge clk);
        iow_n_i = 1'b1;
        #1;
        expect_now("R2 not visible before trailing sample");
        @(negedge clk);
        mdl[3] = 8'hC4;
        expect_now("R2 visible after trailing sample");

        // R7: lane enables.
        out_en_i = 4'b1011;
        @(negedge clk);
        expect_now("R7 lane2 hidden");
        out_en_i = 4'b0000;
        @(negedge clk);
        expect_now("R7 all lanes hidden");
        out_en_i = 4'hF;
        @(negedge clk);
        expect_now("R7 stored bytes reappear");

        // R8: move the window with the switches.
        base_sw_i = 14'h0088;
        bus_write(16'h0301, 8'h42, 1'b0, 1'b0, "R8 old window ignored");
        bus_write(16'h0221, 8'h42, 1'b0, 1'b1, "R8 new window lane1");

        // R1: a later reset clears the latches.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
        expect_now("R1 reset clears latches");
        rst_n = 1'b1;
        @(negedge clk);
        expect_now("R1 clear after release");

        #10;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule